// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Segment

This block is one piece of a boundary-scan data register that covers a group of bidirectional I/O pins. It sits between the core logic and the pad cells. Each pin gets two scan cells. The first is a control cell that decides whether the pad driver is enabled. The second is a data cell that supplies the value driven onto the pin and observes the level actually present on the pin.

In normal mode the core's output, output enable and input pass straight through the segment, and the cells only watch them. That is enough to sample a running system. In test mode the pad driver and its enable come from the update stage of the cells, so the tester sets every pin directly.

The TAP controller supplies the capture, shift and update strobes. These act on the scan clock. The segment has one serial input and one serial output, so several segments can be concatenated into a full chain. The pin count is a parameter, and the chain holds two cells per pin.

Top module: `bscan_bidir_seg`

## Requirements
- R1: Chain position 2i holds the control cell of pin i and position 2i+1 holds its data cell. Position 0 is nearest the serial output. On a capture strobe the control cell at position 2i loads core_oe[i].
- R2: In test mode, a control cell whose update stage holds 0 forces pad_oe[i] low, so the pin floats.
- R3: A synchronous reset clears every shift stage and every update stage to 0. After reset in test mode, pad_oe and pad_do are all zero and so is 0.
- R4: On a capture strobe the data cell of pin i loads pad_di[i]. This is the observed pin level, whatever the state of the pin's driver enable.
- R5: In normal mode (mode_test=0), pad_oe equals core_oe and pad_do equals core_do in the same cycle. core_di always equals pad_di.
- R6: An update strobe copies every shift stage into its update stage. In test mode pad_oe[i] then shows the update stage at position 2i, and pad_do[i] shows the update stage at position 2i+1.
- R7: Without an update strobe the update stages hold their values, so shifting leaves pad_oe and pad_do unchanged in test mode.
- R8: Each shift strobe moves the chain one place toward position 0. The cell at position 2*NPINS-1 loads si, and so always shows position 0. A vector shifted in over 2*NPINS strobes comes back out unchanged over the next 2*NPINS strobes, first bit first.
- R9: When capture and shift are asserted in the same cycle, capture takes effect and the shift is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_test | input | 1 | 1 = pads driven from update stages, 0 = pass-through |
| cap_en | input | 1 | Capture strobe |
| shf_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| si | input | 1 | Serial input (enters highest position) |
| so | output | 1 | Serial output (position 0) |
| core_do | input | NPINS | Core output data per pin |
| core_oe | input | NPINS | Core output enable per pin |
| core_di | output | NPINS | Pin level returned to core |
| pad_do | output | NPINS | Data toward pad driver |
| pad_oe | output | NPINS | Enable toward pad driver |
| pad_di | input | NPINS | Level observed at the pad |

## Verification
The pass-through outputs are combinational. The bench therefore checks them in the same cycle in which it changes the core or pad inputs, 1 ns after the edge. A capture or shift strobe changes so one clock edge later. An update strobe changes pad_oe and pad_do in test mode one edge later. The bench drives every strobe for exactly one edge. It reads so before each shift edge, so that captured bit k is read after k shift edges. It compares the pad outputs only once the update edge has passed, and it also checks them just before that edge to confirm that they held during shifting.

// File: rtl/bsc_seg_pkg.sv
package bsc_seg_pkg;

    // Operation applied to the shift stage of every cell in one scan clock.
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } cell_op_e;

    // Per-cell storage: the serial stage and the parallel hold stage.
    typedef struct packed {
        logic shf;
        logic upd;
    } cell_state_t;

    // Driver side of one pin: enable plus data.
    typedef struct packed {
        logic oe;
        logic dat;
    } pin_drive_t;

    // Values loaded by reset: enables off, data arbitrary but fixed to 0.
    localparam logic CTRL_SAFE = 1'b0;
    localparam logic DATA_SAFE = 1'b0;

    // Two cells per pin.
    function automatic int unsigned seg_len(input int unsigned pins);
        return 2 * pins;
    endfunction

    // Capture wins over shift when both strobes are present.
    function automatic cell_op_e pick_op(input logic cap, input logic shf);
        if (cap)
            return OP_CAPTURE;
        else if (shf)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/bsc_cell.sv
module bsc_cell
    import bsc_seg_pkg::*;
#(
    parameter logic SAFE = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  cell_op_e op,
    input  logic     upd_en,
    input  logic     scan_in,
    input  logic     cap_val,
    output logic     scan_out,
    output logic     hold
);

    cell_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.shf <= 1'b0;
            st.upd <= SAFE;
        end else begin
            case (op)
                OP_CAPTURE: st.shf <= cap_val;
                OP_SHIFT:   st.shf <= scan_in;
                default:    st.shf <= st.shf;
            endcase
            if (upd_en)
                st.upd <= st.shf;
        end
    end

    assign scan_out = st.shf;
    assign hold     = st.upd;

    // R1 / R4: a capture loads the parallel value seen on that edge.
    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CAPTURE) |=> (scan_out == $past(cap_val)));

    // R8: a shift loads the upstream serial bit.
    p_shift_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (scan_out == $past(scan_in)));

    // R6: update copies the serial stage.
    p_update_r6: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (hold == $past(scan_out)));

    // R7: no update strobe, no change in the hold stage.
    p_upd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(hold));

endmodule

// File: rtl/bsc_pin_pair.sv
module bsc_pin_pair
    import bsc_seg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cell_op_e op,
    input  logic     upd_en,
    input  logic     mode_test,
    input  logic     scan_in,
    output logic     scan_out,
    input  logic     core_do,
    input  logic     core_oe,
    output logic     core_di,
    output logic     pad_do,
    output logic     pad_oe,
    input  logic     pad_di
);

    logic       mid;        // data cell serial out -> control cell serial in
    pin_drive_t core_side;
    pin_drive_t test_side;
    pin_drive_t pad_side;

    // Higher position: data cell, watches the real pin level.
    bsc_cell #(.SAFE(DATA_SAFE)) u_dat (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .upd_en   (upd_en),
        .scan_in  (scan_in),
        .cap_val  (pad_di),
        .scan_out (mid),
        .hold     (test_side.dat)
    );

    // Lower position: control cell, gates the driver enable.
    bsc_cell #(.SAFE(CTRL_SAFE)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .upd_en   (upd_en),
        .scan_in  (mid),
        .cap_val  (core_oe),
        .scan_out (scan_out),
        .hold     (test_side.oe)
    );

    always_comb begin
        core_side.oe  = core_oe;
        core_side.dat = core_do;
        pad_side      = mode_test ? test_side : core_side;
    end

    assign pad_oe  = pad_side.oe;
    assign pad_do  = pad_side.dat;
    assign core_di = pad_di;

    // R2: loading a 0 into the control hold stage floats the pin in test mode.
    p_float_r2: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !scan_out) |=> (!mode_test || !pad_oe));

    // R3: the cycle after reset, test mode leaves the pin undriven.
    p_reset_safe_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && mode_test) |-> (!pad_oe && !pad_do));

endmodule

// File: rtl/bscan_bidir_seg.sv
module bscan_bidir_seg
    import bsc_seg_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_test,
    input  logic             cap_en,
    input  logic             shf_en,
    input  logic             upd_en,
    input  logic             si,
    output logic             so,
    input  logic [NPINS-1:0] core_do,
    input  logic [NPINS-1:0] core_oe,
    output logic [NPINS-1:0] core_di,
    output logic [NPINS-1:0] pad_do,
    output logic [NPINS-1:0] pad_oe,
    input  logic [NPINS-1:0] pad_di
);

    cell_op_e         op;
    logic [NPINS:0]   link;     // link[i] = serial out of pin pair i

    assign op          = pick_op(cap_en, shf_en);
    assign link[NPINS] = si;
    assign so          = link[0];

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        bsc_pin_pair u_pair (
            .clk       (clk),
            .rst       (rst),
            .op        (op),
            .upd_en    (upd_en),
            .mode_test (mode_test),
            .scan_in   (link[i+1]),
            .scan_out  (link[i]),
            .core_do   (core_do[i]),
            .core_oe   (core_oe[i]),
            .core_di   (core_di[i]),
            .pad_do    (pad_do[i]),
            .pad_oe    (pad_oe[i]),
            .pad_di    (pad_di[i])
        );
    end

    // R9: simultaneous capture and shift behaves as capture at position 0.
    p_cap_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_en && shf_en) |=> (so == $past(core_oe[0])));

    // R5: core input always mirrors the pad.
    p_core_in_r5: assert property (@(posedge clk) disable iff (rst)
        core_di == pad_di);

endmodule

// File: tb/bscan_bidir_seg_tb.sv
module bscan_bidir_seg_tb;
    import bsc_seg_pkg::*;

    localparam int unsigned NP  = 8;
    localparam int unsigned LEN = seg_len(NP);

    logic          clk = 1'b0;
    logic          rst, mode_test, cap_en, shf_en, upd_en, si, so;
    logic [NP-1:0] core_do, core_oe, core_di, pad_do, pad_oe, pad_di;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bscan_bidir_seg #(.NPINS(NP)) u_dut (
        .clk(clk), .rst(rst), .mode_test(mode_test), .cap_en(cap_en),
        .shf_en(shf_en), .upd_en(upd_en), .si(si), .so(so),
        .core_do(core_do), .core_oe(core_oe), .core_di(core_di),
        .pad_do(pad_do), .pad_oe(pad_oe), .pad_di(pad_di)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // bit 2i = enable of pin i, bit 2i+1 = data of pin i
    function automatic logic [LEN-1:0] weave(input logic [NP-1:0] en, input logic [NP-1:0] dat);
        logic [LEN-1:0] v;
        for (int i = 0; i < NP; i++) begin
            v[2*i]   = en[i];
            v[2*i+1] = dat[i];
        end
        return v;
    endfunction

    function automatic logic [NP-1:0] evens(input logic [LEN-1:0] v);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[i] = v[2*i];
        return r;
    endfunction

    function automatic logic [NP-1:0] odds(input logic [LEN-1:0] v);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[i] = v[2*i+1];
        return r;
    endfunction

    task automatic shift_vec(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
        for (int k = 0; k < LEN; k++) begin
            dout[k] = so;
            si      = din[k];
            shf_en  = 1'b1;
            step();
        end
        shf_en = 1'b0;
        si     = 1'b0;
    endtask

    task automatic pulse_cap(input logic with_shift);
        cap_en = 1'b1;
        shf_en = with_shift;
        step();
        cap_en = 1'b0;
        shf_en = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_en = 1'b1;
        step();
        upd_en = 1'b0;
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [LEN-1:0] got, held_vec, dummy;
        rst = 1'b1; mode_test = 1'b1; cap_en = 1'b0; shf_en = 1'b0; upd_en = 1'b0;
        si = 1'b0; core_do = '1; core_oe = '1; pad_di = '0;
        repeat (3) step();
        rst = 1'b0;

        // R3: safe state after reset
        chk("R3 pad_oe", 64'(pad_oe), 64'd0);
        chk("R3 pad_do", 64'(pad_do), 64'd0);
        chk("R3 so", 64'(so), 64'd0);

        // R5: pass-through sweep in normal mode
        mode_test = 1'b0;
        for (int p = 0; p < 64; p++) begin
            core_oe = NP'(p * 37 + 5);
            core_do = NP'(p * 91) ^ NP'(8'hA5);
            pad_di  = NP'(p * 13 + 200);
            #1;
            chk("R5 pad_oe", 64'(pad_oe), 64'(core_oe));
            chk("R5 pad_do", 64'(pad_do), 64'(core_do));
            chk("R5 core_di", 64'(core_di), 64'(pad_di));
        end

        // R1/R4/R6/R7/R2: capture, shift out/in, update
        mode_test = 1'b1;
        held_vec  = '0;
        for (int p = 0; p < 32; p++) begin
            logic [LEN-1:0] nv;
            core_oe = NP'(p * 53) ^ NP'(8'h3C);
            core_do = ~core_oe;                 // must not be captured
            pad_di  = NP'(p * 29 + 7);
            nv      = LEN'(p * 40503) ^ LEN'(16'h0F0F);
            pulse_cap(1'b0);
            shift_vec(nv, got);
            chk("R1 ctrl capture", 64'(evens(got)), 64'(core_oe));
            chk("R4 data capture", 64'(odds(got)), 64'(pad_di));
            chk("R7 oe held", 64'(pad_oe), 64'(evens(held_vec)));
            chk("R7 do held", 64'(pad_do), 64'(odds(held_vec)));
            pulse_upd();
            held_vec = nv;
            chk("R6 pad_oe", 64'(pad_oe), 64'(evens(nv)));
            chk("R6 pad_do", 64'(pad_do), 64'(odds(nv)));
            chk("R2 float", 64'(pad_oe & ~evens(nv)), 64'd0);
            mode_test = 1'b0;
            #1;
            chk("R5 back to core", 64'(pad_oe), 64'(core_oe));
            mode_test = 1'b1;
            #1;
        end

        // R8: round trip of length 2*NPINS
        for (int p = 0; p < 16; p++) begin
            logic [LEN-1:0] v;
            v = LEN'(p * 4369) ^ LEN'(16'h8001) ^ LEN'(1 << p);
            shift_vec(v, dummy);
            shift_vec('0, got);
            chk("R8 round trip", 64'(got), 64'(v));
        end

        // R9: capture beats simultaneous shift
        core_oe = 8'hC5;
        pad_di  = 8'h3A;
        pulse_cap(1'b1);
        shift_vec('0, got);
        chk("R9 capture priority", 64'(got), 64'(weave(core_oe, pad_di)));

        // R3: reset mid-run clears update stages again
        shift_vec('1, dummy);
        pulse_upd();
        chk("R6 all ones", 64'(pad_oe), 64'({NP{1'b1}}));
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R3 reset oe", 64'(pad_oe), 64'd0);
        chk("R3 reset do", 64'(pad_do), 64'd0);
        chk("R3 reset so", 64'(so), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule